// File: doc/BRIEF.md
# Complemented Logical Operation Unit

This unit executes the five inverting bitwise instructions of a 32-bit register model held in 64-bit registers. The five are AND-with-complement, OR-with-complement, NOR, NAND and equivalence. It decodes the instruction word and picks the operation. It works on the low 32 bits of the two source operands and returns a 64-bit result whose upper half is always zero, so inverted upper bits never reach the destination register. When the record bit is set, it also produces a 4-bit condition field for CR0, judged from the 32-bit result read as a signed number.

Operations enter and leave through valid/ready handshakes, with one register stage between them. The input side accepts an item when `in_valid` and `in_ready` are both high on a clock edge. The output side hands over an item when `out_valid` and `out_ready` are both high. While the output is stalled, every output field stays frozen and `in_ready` is low, so back-pressure passes straight to the source. Once the stalled item is taken, the stage can accept a new item in that same cycle. The summary-overflow flag is a plain input sampled alongside each accepted item.

Top module: `cmpl_logic_unit`

## Requirements
- R1: With primary opcode 31 (instruction bits 31:26) and extended opcode 60 (bits 10:1), the result's low 32 bits are rs AND NOT rb.
- R2: Extended opcode 412 gives rs OR NOT rb over the low 32 bits.
- R3: Extended opcode 124 gives NOT(rs OR rb). With rs equal to rb this acts as a bitwise NOT, so 0xFF gives 0x00000000FFFFFF00.
- R4: Extended opcode 476 gives NOT(rs AND rb) over the low 32 bits.
- R5: Extended opcode 284 gives NOT(rs XOR rb). Equivalence of a value with itself gives 0x00000000FFFFFFFF.
- R6: Bits 63:32 of every result are zero, whatever the upper halves of the operands hold.
- R7: The destination index comes from bits 20:16, the rs operand is named by bits 25:21, and rb by bits 15:11. The destination index is reported on `out_dst`.
- R8: When the record bit (bit 0) is set on a supported operation, `out_cr_valid` is 1 and `out_cr` is {LT, GT, EQ, SO}. LT means result bit 31 is set, EQ means the 32-bit result is zero, and GT means neither. SO copies `in_so`. When the record bit is clear, `out_cr_valid` is 0 and `out_cr` is 0.
- R9: Any other primary or extended opcode gives `out_wr_en` = 0, `out_cr_valid` = 0 and a zero result. Such an item still passes through the handshake.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all output fields hold their values. Items leave in the order they entered.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The stage can accept an operation |
| in_instr | input | 32 | Instruction word |
| in_src_s | input | 64 | Value of the rs register |
| in_src_b | input | 64 | Value of the rb register |
| in_so | input | 1 | Summary-overflow flag copied into CR0 |
| out_valid | output | 1 | A result is offered |
| out_ready | input | 1 | The consumer takes the result |
| out_dst | output | 5 | Destination register index |
| out_result | output | 64 | Result, upper half zero |
| out_wr_en | output | 1 | The result should be written |
| out_cr | output | 4 | CR0 field {LT, GT, EQ, SO} |
| out_cr_valid | output | 1 | The CR0 field should be written |

## Verification
The bench builds the unit with its default widths: 64-bit registers and a 32-bit word. Each operand's upper half carries deliberate garbage, which makes any leak of inverted upper bits visible in the result. A 32-bit word inside a wider register also brings sign bit 31 and the zero test into reach for the condition field. An output-ready pattern that stalls for several cycles, followed by a stretch at full rate, exercises both the hold behaviour and back-to-back acceptance.

// File: rtl/cl_pkg.sv
package cl_pkg;
  localparam int unsigned PRIMARY_OP = 31;
  localparam int unsigned XO_ANDC    = 60;
  localparam int unsigned XO_NOR     = 124;
  localparam int unsigned XO_EQV     = 284;
  localparam int unsigned XO_ORC     = 412;
  localparam int unsigned XO_NAND    = 476;
  localparam int unsigned IDX_W      = 5;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ANDC = 3'd1,
    OP_ORC  = 3'd2,
    OP_NOR  = 3'd3,
    OP_NAND = 3'd4,
    OP_EQV  = 3'd5
  } bitop_e;

  typedef struct packed {
    bitop_e             op;
    logic [IDX_W-1:0]   dst;
    logic               rec;
    logic               legal;
  } dec_t;
endpackage

// File: rtl/cl_decode.sv
module cl_decode
  import cl_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec,
  output logic [IDX_W-1:0] src_s_idx,
  output logic [IDX_W-1:0] src_b_idx
);
  logic [5:0] primary;
  logic [9:0] xo;

  assign primary   = instr[31:26];
  assign xo        = instr[10:1];
  assign src_s_idx = instr[25:21];
  assign src_b_idx = instr[15:11];

  always_comb begin
    dec.dst = instr[20:16];
    dec.rec = instr[0];
    dec.op  = OP_NONE;
    if (primary == 6'(PRIMARY_OP)) begin
      case (xo)
        10'(XO_ANDC): dec.op = OP_ANDC;
        10'(XO_ORC):  dec.op = OP_ORC;
        10'(XO_NOR):  dec.op = OP_NOR;
        10'(XO_NAND): dec.op = OP_NAND;
        10'(XO_EQV):  dec.op = OP_EQV;
        default:      dec.op = OP_NONE;
      endcase
    end
    dec.legal = (dec.op != OP_NONE);
  end
endmodule

// File: rtl/cl_bitop.sv
module cl_bitop
  import cl_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  bitop_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W-1:0] full;
  logic [DATA_W-1:0] keep;

  always_comb begin
    case (op)
      OP_ANDC: full = a & ~b;
      OP_ORC:  full = a | ~b;
      OP_NOR:  full = ~(a | b);
      OP_NAND: full = ~(a & b);
      OP_EQV:  full = ~(a ^ b);
      default: full = '0;
    endcase
  end

  generate
    if (DATA_W > WORD_W) begin : g_trunc
      localparam int unsigned HI_W = DATA_W - WORD_W;
      assign keep = {{HI_W{1'b0}}, {WORD_W{1'b1}}};
    end else begin : g_flat
      assign keep = '1;
    end
  endgenerate

  assign y = full & keep;
endmodule

// File: rtl/cl_cr0.sv
module cl_cr0 #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              so,
  input  logic              en,
  output logic [3:0]        cr
);
  logic lt, eq, gt;
  assign lt = word[WORD_W-1];
  assign eq = (word == '0);
  assign gt = !lt && !eq;
  assign cr = en ? {lt, gt, eq, so} : 4'b0000;
endmodule

// File: rtl/cmpl_logic_unit.sv
module cmpl_logic_unit
  import cl_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  input  logic [DATA_W-1:0] in_src_s,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic              in_so,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [3:0]        out_cr,
  output logic              out_cr_valid
);
  dec_t              dec;
  logic [IDX_W-1:0]  s_idx, b_idx;
  logic [DATA_W-1:0] res;
  logic [3:0]        cr_n;
  logic              cr_en;
  logic              in_fire;

  cl_decode u_dec (
    .instr     (in_instr),
    .dec       (dec),
    .src_s_idx (s_idx),
    .src_b_idx (b_idx)
  );

  cl_bitop #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_op (
    .op (dec.op),
    .a  (in_src_s),
    .b  (in_src_b),
    .y  (res)
  );

  assign cr_en = dec.legal && dec.rec;

  cl_cr0 #(.WORD_W(WORD_W)) u_cr (
    .word (res[WORD_W-1:0]),
    .so   (in_so),
    .en   (cr_en),
    .cr   (cr_n)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_dst      <= '0;
      out_result   <= '0;
      out_wr_en    <= 1'b0;
      out_cr       <= '0;
      out_cr_valid <= 1'b0;
    end else begin
      if (in_fire) begin
        out_valid    <= 1'b1;
        out_dst      <= dec.dst;
        out_result   <= res;
        out_wr_en    <= dec.legal;
        out_cr       <= cr_n;
        out_cr_valid <= cr_en;
      end else if (out_ready) begin
        out_valid    <= 1'b0;
      end
    end
  end

  logic unused_idx;
  assign unused_idx = ^{s_idx, b_idx};
endmodule

// File: rtl/cl_unit_chk.sv
module cl_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [4:0]        out_dst,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic [3:0]        out_cr,
  input logic              out_cr_valid
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_dst)
      && $stable(out_cr) && $stable(out_cr_valid) && $stable(out_wr_en));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result >> WORD_W) == '0);

  // R9
  cr_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_valid |-> out_wr_en);

  // R8
  cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_valid |-> $countones(out_cr[3:1]) == 1);

  // R8
  cr_eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cr_valid && out_cr[1] |-> out_result == '0);

  // R9
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wr_en |-> out_result == '0 && out_cr == 4'b0000);
endmodule

bind cmpl_logic_unit cl_unit_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_dst      (out_dst),
  .out_result   (out_result),
  .out_wr_en    (out_wr_en),
  .out_cr       (out_cr),
  .out_cr_valid (out_cr_valid)
);

// File: tb/cmpl_logic_unit_test.sv
module cmpl_logic_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [63:0] in_src_s = '0;
  logic [63:0] in_src_b = '0;
  logic        in_so = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_dst;
  logic [63:0] out_result;
  logic        out_wr_en;
  logic [3:0]  out_cr;
  logic        out_cr_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic bp_on = 1'b0;

  typedef struct {
    string       tag;
    logic [4:0]  dst;
    logic [63:0] res;
    logic        wr;
    logic [3:0]  cr;
    logic        crv;
  } exp_t;

  exp_t sb[$];

  always #10 clk = ~clk;

  cmpl_logic_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_src_s(in_src_s), .in_src_b(in_src_b), .in_so(in_so),
    .out_valid(out_valid), .out_ready(out_ready), .out_dst(out_dst),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_cr(out_cr),
    .out_cr_valid(out_cr_valid)
  );

  function automatic logic [31:0] enc(input int prim, input int xo, input int d,
                                      input int s, input int b, input bit rc);
    return {6'(prim), 5'(s), 5'(d), 5'(b), 10'(xo), rc};
  endfunction

  function automatic exp_t model(input string tag, input logic [31:0] ins,
                                 input logic [63:0] s, input logic [63:0] b, input logic so);
    exp_t e;
    logic [31:0] a32, b32, r;
    bit ok;
    a32 = s[31:0];
    b32 = b[31:0];
    ok = 1;
    r = '0;
    if (ins[31:26] != 6'd31) ok = 0;
    else case (ins[10:1])
      10'd60:  r = a32 & ~b32;
      10'd412: r = a32 | ~b32;
      10'd124: r = ~(a32 | b32);
      10'd476: r = ~(a32 & b32);
      10'd284: r = ~(a32 ^ b32);
      default: ok = 0;
    endcase
    e.tag = tag;
    e.dst = ins[20:16];
    e.res = {32'h0, r};
    e.wr  = ok;
    e.crv = ok && ins[0];
    if (e.crv) e.cr = {$signed(r) < 0, $signed(r) > 0, r == 0, so};
    else e.cr = 4'b0000;
    return e;
  endfunction

  task automatic send(input string tag, input logic [31:0] ins,
                      input logic [63:0] s, input logic [63:0] b, input logic so);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
    in_src_s = s;
    in_src_b = b;
    in_so    = so;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(tag, ins, s, b, so));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // stall pattern on the output side
  always @(negedge clk) begin
    cyc++;
    out_ready = bp_on ? ((cyc % 5) == 0 || (cyc % 7) == 3) : 1'b1;
  end

  // monitor
  logic        held_v = 1'b0;
  logic [63:0] held_r;
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (held_v) check("R10", out_result === held_r, "held result", out_result, held_r);
      held_v = !out_ready;
      held_r = out_result;
      if (!out_ready) check("R10", in_ready === 1'b0, "in_ready under stall", 64'(in_ready), 64'd0);
      if (out_ready) begin
        if (sb.size() == 0) begin
          check("R10", 1'b0, "unexpected output", out_result, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, out_result === e.res, "result", out_result, e.res);
          check(e.tag, out_dst === e.dst, "dst (R7)", 64'(out_dst), 64'(e.dst));
          check(e.tag, out_wr_en === e.wr, "wr_en", 64'(out_wr_en), 64'(e.wr));
          check(e.tag, out_cr_valid === e.crv, "cr_valid (R8)", 64'(out_cr_valid), 64'(e.crv));
          check(e.tag, out_cr === e.cr, "cr (R8)", 64'(out_cr), 64'(e.cr));
        end
      end
    end else begin
      held_v = 1'b0;
    end
  end

  localparam logic [63:0] JUNK = 64'hA5C3_7E19_0000_0000;

  initial begin
    fork
      begin
        #(20 * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    // R11 reset state
    check("R11", out_valid === 1'b0, "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R11", out_valid === 1'b0, "out_valid after reset", 64'(out_valid), 64'd0);
    check("R11", in_ready === 1'b1, "in_ready after reset", 64'(in_ready), 64'd1);

    // R1 and R6: clearing low bits, upper garbage on operands
    send("R1", enc(31, 60, 5, 3, 4, 0), JUNK | 64'hFFFF_FFFF, JUNK | 64'hF, 0);
    send("R6", enc(31, 60, 6, 3, 4, 1), 64'hFFFF_FFFF_0000_1234, 64'hFFFF_FFFF_0000_0000, 0);
    // R2
    send("R2", enc(31, 412, 7, 1, 2, 1), JUNK | 64'h0000_00F0, JUNK | 64'hFFFF_FF0F, 1);
    send("R2", enc(31, 412, 8, 1, 2, 0), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    // R3 as bitwise NOT
    send("R3", enc(31, 124, 5, 3, 3, 0), 64'hFF, 64'hFF, 0);
    send("R3", enc(31, 124, 9, 3, 4, 1), JUNK | 64'h8000_0000, JUNK | 64'h7FFF_FFFF, 0);
    // R4
    send("R4", enc(31, 476, 10, 1, 2, 1), JUNK | 64'hF0F0_F0F0, 64'hFF00_FF00, 1);
    send("R4", enc(31, 476, 11, 1, 2, 1), 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0);
    // R5 self equivalence
    send("R5", enc(31, 284, 3, 3, 3, 1), 64'h0, 64'h0, 0);
    send("R5", enc(31, 284, 12, 3, 4, 1), JUNK | 64'h1234_5678, 64'h1234_5679, 1);
    // R7 field positions
    send("R7", enc(31, 60, 31, 17, 9, 0), 64'hFFFF_0000, 64'h00FF_0000, 0);
    // R8 sign from bit 31, SO passthrough, GT, record bit clear
    send("R8", enc(31, 412, 2, 1, 2, 1), 64'h0, 64'h8000_0000, 1);
    send("R8", enc(31, 60, 2, 1, 2, 1), 64'h0000_0001, 64'h0, 1);
    send("R8", enc(31, 476, 2, 1, 2, 0), 64'h1, 64'h1, 1);
    // R9 unsupported codes
    send("R9", enc(31, 444, 4, 1, 2, 1), 64'h1234, 64'h5678, 1);
    send("R9", enc(30, 60, 4, 1, 2, 1), 64'hFFFF_FFFF, 64'h0, 0);
    send("R9", enc(31, 28, 4, 1, 2, 1), 64'hFFFF_FFFF, 64'h0, 0);

    // R10 with back-pressure, then at full rate
    bp_on = 1'b1;
    for (int i = 0; i < 24; i++)
      send("R10", enc(31, (i % 2) ? 124 : 284, i % 32, 1, 2, i % 3 == 0),
           {32'hDEAD_0000 + 32'(i), 32'h0101_0101 * 32'(i)}, 64'(32'h1357_9BDF ^ 32'(i * 77)), i % 2);
    bp_on = 1'b0;
    for (int i = 0; i < 12; i++)
      send("R10", enc(31, 476, i, 4, 5, 1), 64'(32'hFFFF_FFF0 + 32'(i)), 64'(32'h0F0F_0F0F << i), 0);

    for (int i = 0; i < 40 && sb.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    if (sb.size() != 0) check("R10", 1'b0, "items left undelivered", 64'(sb.size()), 64'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule